// File: doc/BRIEF.md
# USB Host Controller Operational Registers

This block holds the I/O-mapped operational registers of a full-speed USB host controller, together with the run/stop frame engine and the interrupt line. Software reaches it through a simple byte/word/dword access port over a 32-byte window. It writes the command word to start or stop the controller, programs the frame-list base and start-of-frame timing, and services interrupts by writing ones to the status word.

A schedule walker outside this block raises `frame_tick` once per millisecond. It presents the interrupt causes collected during the frame just finished on `frame_causes`. The block folds those causes into a hidden two-bit register that keeps completion interrupts apart from short-packet interrupts, sets the status interrupt flag and advances the 11-bit frame counter. Resume, host-system-error and process-error events arrive as single-cycle pulses. The interrupt request is a registered function of status, hidden causes and enables.

Top module: `usb_hc_opregs`

## Requirements
- R1: After reset the command, status, interrupt-enable, frame-number and frame-list-base registers read 0, SOF timing reads 64, `irq`, `bus_reset` and `engine_run` are 0.
- R2: A word write at offset 0x00 without bit 1 or bit 2 stores the value. Bit 0 rising from 0 to 1 clears status bit 5 (halted) and sets `engine_run`. Writing bit 0 as 0 sets halted.
- R3: A word write at offset 0x00 with bit 1 or bit 2 set leaves the value unstored. It clears command, status, interrupt enable, hidden causes and frame-list base, and sets SOF timing to 64. When bit 2 is set, `bus_reset` is high for the one cycle after the write.
- R4: A `frame_tick` while `engine_run` is high and command bit 0 is 1 increments the frame number modulo 2048. While command bit 0 is 0, the tick sets halted and clears `engine_run`, and later ticks change nothing.
- R5: A word write at offset 0x06 loads the frame number, masked to 11 bits, only while halted is set. Otherwise the write is ignored.
- R6: A word write at offset 0x02 clears each status bit written as one. A one in bit 0 also clears both hidden cause bits.
- R7: On a running tick with command bit 0 set, a nonzero `frame_causes` is ORed into the hidden causes and sets status bit 0 before the frame number advances.
- R8: `irq` is registered, one cycle after the state that causes it. It is high when any of these holds: hidden cause 0 with enable bit 2, hidden cause 1 with enable bit 3, status bit 1 with enable bit 0, status bit 2 with enable bit 1, status bit 3, or status bit 4.
- R9: A `resume_evt` sets command bit 4 and status bit 2 only when command bit 3 is set.
- R10: `host_err_evt` sets status bit 3 and `proc_err_evt` sets status bit 4.
- R11: A dword write at 0x08 stores the frame-list base with bits 11:0 forced to 0. A byte write at 0x0C stores SOF timing. An access of the wrong size to either offset is ignored.
- R12: Reads return 0xFF for unmapped bytes, 0xFF7F for unmapped words and 0xFFFFFFFF for unmapped dwords. Only address bits 4:0 are decoded. Size code 0 means byte, 1 word, 2 dword, and 3 is no access (reads 0).
- R13: Within one cycle, the tick is applied first, then events, then the bus write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | Access strobe |
| acc_wr | input | 1 | 1 write, 0 read |
| acc_size | input | 2 | 0 byte, 1 word, 2 dword, 3 none |
| acc_addr | input | ADDR_W | Byte offset; bits 4:0 decoded |
| acc_wdata | input | 32 | Write data, low-aligned |
| acc_rdata | output | 32 | Read data for current address and size |
| frame_tick | input | 1 | One-cycle 1 ms frame pulse |
| frame_causes | input | 2 | Causes pending from the previous frame |
| resume_evt | input | 1 | Remote resume detected |
| host_err_evt | input | 1 | Host system error |
| proc_err_evt | input | 1 | Schedule process error |
| irq | output | 1 | Interrupt request level |
| bus_reset | output | 1 | One-cycle bus reset pulse |
| engine_run | output | 1 | Frame engine is running |

## Verification
A corrupted hidden cause bit or enable bit shows up on `irq` exactly one cycle after the state goes wrong. Drift in the frame counter or the halted flag appears on the first read of offsets 0x06 or 0x02. It also appears indirectly when a later frame-number write is ignored or accepted. A lost run flag shows on `engine_run` right after the edge and stops ticks from counting frames. A reference model stepped on every clock compares all of these each cycle, so a divergence is reported in the cycle it first reaches a port.

// File: rtl/usb_hc_opregs.sv
module usb_hc_opregs #(
  parameter int ADDR_W    = 8,
  parameter int FRNUM_W   = 11,
  parameter int SOF_RESET = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              acc_wr,
  input  logic [1:0]        acc_size,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [31:0]       acc_wdata,
  output logic [31:0]       acc_rdata,
  input  logic              frame_tick,
  input  logic [1:0]        frame_causes,
  input  logic              resume_evt,
  input  logic              host_err_evt,
  input  logic              proc_err_evt,
  output logic              irq,
  output logic              bus_reset,
  output logic              engine_run
);

  localparam int FLB_LSB = 12;

  logic [15:0]        cmd_q, intr_q, cmd_n;
  logic [5:0]         sts_q, sts_n;
  logic [1:0]         cause_q, cause_n;
  logic [FRNUM_W-1:0] frnum_q, frnum_n;
  logic [31-FLB_LSB:0] flb_q;
  logic [7:0]         sof_q;
  logic               run_q, run_n, irq_q, busrst_q;

  logic [4:0] off;
  logic unused_addr_hi;
  assign off = acc_addr[4:0];
  assign unused_addr_hi = ^acc_addr[ADDR_W-1:5];

  logic wr, wr_b, wr_w, wr_d;
  assign wr   = acc_en & acc_wr;
  assign wr_b = wr && acc_size == 2'd0;
  assign wr_w = wr && acc_size == 2'd1;
  assign wr_d = wr && acc_size == 2'd2;

  logic wr_cmd, wr_sts, wr_ien, wr_frn, wr_flb, wr_sof, full_rst;
  assign wr_cmd   = wr_w && off == 5'h00;
  assign wr_sts   = wr_w && off == 5'h02;
  assign wr_ien   = wr_w && off == 5'h04;
  assign wr_frn   = wr_w && off == 5'h06;
  assign wr_flb   = wr_d && off == 5'h08;
  assign wr_sof   = wr_b && off == 5'h0C;
  assign full_rst = wr_cmd && (acc_wdata[1] || acc_wdata[2]);

  always_comb begin
    cmd_n   = cmd_q;
    sts_n   = sts_q;
    cause_n = cause_q;
    frnum_n = frnum_q;
    run_n   = run_q;
    if (frame_tick && run_q) begin
      if (!cmd_q[0]) begin
        sts_n[5] = 1'b1;
        run_n    = 1'b0;
      end else begin
        if (frame_causes != 2'b00) begin
          cause_n  = cause_n | frame_causes;
          sts_n[0] = 1'b1;
        end
        frnum_n = frnum_q + 1'b1;
      end
    end
    if (resume_evt && cmd_q[3]) begin
      cmd_n[4] = 1'b1;
      sts_n[2] = 1'b1;
    end
    if (host_err_evt) sts_n[3] = 1'b1;
    if (proc_err_evt) sts_n[4] = 1'b1;
    if (wr_cmd && !full_rst) begin
      if (acc_wdata[0] && !cmd_q[0]) begin
        run_n    = 1'b1;
        sts_n[5] = 1'b0;
      end else if (!acc_wdata[0]) begin
        sts_n[5] = 1'b1;
      end
      cmd_n = acc_wdata[15:0];
    end
    if (wr_sts) begin
      sts_n = sts_n & ~acc_wdata[5:0];
      if (acc_wdata[0]) cause_n = 2'b00;
    end
    if (wr_frn && sts_n[5]) frnum_n = acc_wdata[FRNUM_W-1:0];
  end

  logic irq_d;
  assign irq_d = (cause_q[0] && intr_q[2]) || (cause_q[1] && intr_q[3]) ||
                 (sts_q[1] && intr_q[0]) || (sts_q[2] && intr_q[1]) ||
                 sts_q[3] || sts_q[4];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q    <= '0;
      sts_q    <= '0;
      intr_q   <= '0;
      cause_q  <= '0;
      frnum_q  <= '0;
      flb_q    <= '0;
      sof_q    <= 8'(SOF_RESET);
      run_q    <= 1'b0;
      irq_q    <= 1'b0;
      busrst_q <= 1'b0;
    end else begin
      frnum_q  <= frnum_n;
      run_q    <= run_n;
      irq_q    <= irq_d;
      busrst_q <= full_rst && acc_wdata[2];
      if (full_rst) begin
        cmd_q   <= '0;
        sts_q   <= '0;
        intr_q  <= '0;
        cause_q <= '0;
        flb_q   <= '0;
        sof_q   <= 8'(SOF_RESET);
      end else begin
        cmd_q   <= cmd_n;
        sts_q   <= sts_n;
        cause_q <= cause_n;
        if (wr_ien) intr_q <= acc_wdata[15:0];
        if (wr_flb) flb_q  <= acc_wdata[31:FLB_LSB];
        if (wr_sof) sof_q  <= acc_wdata[7:0];
      end
    end
  end

  assign irq        = irq_q;
  assign bus_reset  = busrst_q;
  assign engine_run = run_q;

  always_comb begin
    acc_rdata = '0;
    case (acc_size)
      2'd0: acc_rdata = (off == 5'h0C) ? {24'h0, sof_q} : 32'h0000_00FF;
      2'd1: begin
        case (off)
          5'h00:   acc_rdata = {16'h0, cmd_q};
          5'h02:   acc_rdata = {26'h0, sts_q};
          5'h04:   acc_rdata = {16'h0, intr_q};
          5'h06:   acc_rdata = {{(32-FRNUM_W){1'b0}}, frnum_q};
          default: acc_rdata = 32'h0000_FF7F;
        endcase
      end
      2'd2: acc_rdata = (off == 5'h08) ? {flb_q, {FLB_LSB{1'b0}}} : 32'hFFFF_FFFF;
      default: acc_rdata = '0;
    endcase
  end

  assert_frnum_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_tick && !wr_frn) |=> $stable(frnum_q))
    else $error("frame number moved without tick or write");

  assert_halt_stops_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && frame_tick && !cmd_q[0] && !wr_cmd) |=> !run_q)
    else $error("engine kept running after halting tick");

  assert_frnum_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_frn && !sts_q[5] && !frame_tick) |=> $stable(frnum_q))
    else $error("frame number written while not halted");

  assert_full_reset_R3: assert property (@(posedge clk) disable iff (!rst_n)
    full_rst |=> (cmd_q == 16'h0 && sts_q == 6'h0 && cause_q == 2'b00 &&
                  sof_q == 8'(SOF_RESET)))
    else $error("full reset left state behind");

  assert_resume_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (resume_evt && cmd_q[3] && !wr) |=> (cmd_q[4] && sts_q[2]))
    else $error("resume not recorded while suspended");

  assert_err_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_q[3] || sts_q[4]) |=> irq)
    else $error("error status without interrupt");

endmodule

// File: tb/usb_hc_opregs_test.sv
`timescale 1ns/1ps
module usb_hc_opregs_test;
  logic clk = 0, rst_n = 0;
  logic acc_en = 0, acc_wr = 0;
  logic [1:0] acc_size = 0;
  logic [7:0] acc_addr = 0;
  logic [31:0] acc_wdata = 0;
  logic [31:0] acc_rdata;
  logic frame_tick = 0, resume_evt = 0, host_err_evt = 0, proc_err_evt = 0;
  logic [1:0] frame_causes = 0;
  logic irq, bus_reset, engine_run;

  always #2.5 clk = ~clk;

  usb_hc_opregs uut (.clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
    .acc_size(acc_size), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .acc_rdata(acc_rdata), .frame_tick(frame_tick), .frame_causes(frame_causes),
    .resume_evt(resume_evt), .host_err_evt(host_err_evt), .proc_err_evt(proc_err_evt),
    .irq(irq), .bus_reset(bus_reset), .engine_run(engine_run));

  int checks = 0, failures = 0;
  bit done = 0;
  int m_cmd, m_sts, m_ien, m_cause, m_fr, m_flb, m_sof, m_run, m_irq, m_brst;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int irq_of(int s, int ie, int ca);
    return (((ca & 1) && (ie & 4)) || ((ca & 2) && (ie & 8)) ||
            ((s & 2) && (ie & 1)) || ((s & 4) && (ie & 2)) ||
            (s & 8) || (s & 16)) ? 1 : 0;
  endfunction

  function automatic string tag_of(int sz, int off);
    if (sz == 0) return (off == 12) ? "R11 sof read" : "R12 byte unmapped";
    if (sz == 1) begin
      if (off == 0) return "R2 cmd read";
      if (off == 2) return "R6 status read";
      if (off == 4) return "R8 enable read";
      if (off == 6) return "R5 frnum read";
      return "R12 word unmapped";
    end
    if (sz == 2) return (off == 8) ? "R11 base read" : "R12 dword unmapped";
    return "R12 no-access read";
  endfunction

  task automatic step(input bit en, input bit wr, input int sz, input int ad,
                      input logic [31:0] wd, input bit tk, input int cs,
                      input bit rs, input bit he, input bit pe, input string tag);
    int off, c, s, ie, ca, f, fl, so, r, ni, nb;
    bit fullr;
    logic [31:0] exp;
    acc_en = en; acc_wr = wr; acc_size = 2'(sz); acc_addr = 8'(ad); acc_wdata = wd;
    frame_tick = tk; frame_causes = 2'(cs); resume_evt = rs;
    host_err_evt = he; proc_err_evt = pe;
    #1;
    off = ad & 31;
    if (en && !wr) begin
      case (sz)
        0: exp = (off == 12) ? m_sof : 32'hFF;
        1: exp = (off == 0) ? m_cmd : (off == 2) ? m_sts : (off == 4) ? m_ien :
                 (off == 6) ? m_fr : 32'hFF7F;
        2: exp = (off == 8) ? m_flb : 32'hFFFF_FFFF;
        default: exp = 0;
      endcase
      chk(tag == "" ? tag_of(sz, off) : tag, acc_rdata, exp);
    end
    c = m_cmd; s = m_sts; ie = m_ien; ca = m_cause; f = m_fr; fl = m_flb;
    so = m_sof; r = m_run; ni = irq_of(m_sts, m_ien, m_cause); nb = 0; fullr = 0;
    if (tk && r != 0) begin
      if ((c & 1) == 0) begin s |= 32; r = 0; end
      else begin
        if (cs != 0) begin ca |= cs; s |= 1; end
        f = (f + 1) % 2048;
      end
    end
    if (rs && (c & 8)) begin c |= 16; s |= 4; end
    if (he) s |= 8;
    if (pe) s |= 16;
    if (en && wr) begin
      if (sz == 1 && off == 0) begin
        if (wd[1] || wd[2]) begin fullr = 1; nb = wd[2]; end
        else begin
          if (wd[0] && (c & 1) == 0) begin r = 1; s &= ~32; end
          else if (!wd[0]) s |= 32;
          c = int'(wd[15:0]);
        end
      end
      if (sz == 1 && off == 2) begin s &= ~int'(wd[5:0]); if (wd[0]) ca = 0; end
      if (sz == 1 && off == 4) ie = int'(wd[15:0]);
      if (sz == 1 && off == 6 && (s & 32)) f = int'(wd[10:0]);
      if (sz == 2 && off == 8) fl = int'(wd & 32'hFFFF_F000);
      if (sz == 0 && off == 12) so = int'(wd[7:0]);
    end
    if (fullr) begin c = 0; s = 0; ie = 0; ca = 0; fl = 0; so = 64; end
    @(posedge clk);
    m_cmd = c; m_sts = s; m_ien = ie; m_cause = ca; m_fr = f; m_flb = fl;
    m_sof = so; m_run = r; m_irq = ni; m_brst = nb;
    #1;
    chk("R8 irq", irq, m_irq);
    chk("R3 bus_reset", bus_reset, m_brst);
    chk("R4 engine_run", engine_run, m_run);
    @(negedge clk);
  endtask

  task automatic wrw(input int ad, input int v);
    step(1, 1, 1, ad, v, 0, 0, 0, 0, 0, "");
  endtask
  task automatic rd(input int sz, input int ad, input string tag);
    step(1, 0, sz, ad, 0, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic tick(input int cs);
    step(0, 0, 0, 0, 0, 1, cs, 0, 0, 0, "");
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    m_cmd = 0; m_sts = 0; m_ien = 0; m_cause = 0; m_fr = 0; m_flb = 0;
    m_sof = 64; m_run = 0; m_irq = 0; m_brst = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset values
    rd(1, 0, "R1 cmd"); rd(1, 2, "R1 status"); rd(1, 4, "R1 enable");
    rd(1, 6, "R1 frnum"); rd(2, 8, "R1 base"); rd(0, 12, "R1 sof");
    // R2 start, R7 causes, R8 irq via enable bit 2
    wrw(4, 4);
    wrw(0, 1); rd(1, 2, "R2 halted cleared"); rd(1, 0, "R2 cmd stored");
    tick(1); rd(1, 2, "R7 usbint set"); rd(1, 6, "R7 frame advanced");
    tick(2); tick(0); rd(1, 6, "R4 frame count");
    // R6 write-one-to-clear
    wrw(2, 1); rd(1, 2, "R6 cleared"); tick(0);
    // R4 halt on tick, further ticks ignored
    wrw(0, 0); rd(1, 2, "R2 halted set");
    tick(0); tick(0); tick(3); rd(1, 6, "R4 frozen");
    // R5 frame write while halted, masked
    wrw(6, 32'hFFFF); rd(1, 6, "R5 masked");
    wrw(0, 1); tick(0); rd(1, 6, "R4 wrap to zero");
    wrw(6, 5); rd(1, 6, "R5 ignored while running");
    // R9 resume
    step(0, 0, 0, 0, 0, 0, 0, 1, 0, 0, ""); rd(1, 0, "R9 no suspend");
    wrw(0, 9); step(0, 0, 0, 0, 0, 0, 0, 1, 0, 0, ""); rd(1, 0, "R9 resume");
    wrw(4, 2); tick(0);
    // R10 errors
    wrw(4, 0); step(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, ""); tick(0);
    rd(1, 2, "R10 host error"); wrw(2, 8);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, ""); rd(1, 2, "R10 process error"); wrw(2, 63);
    // R11 base and sof
    step(1, 1, 2, 8, 32'h1234_5FFF, 0, 0, 0, 0, 0, ""); rd(2, 8, "R11 base low zero");
    step(1, 1, 1, 8, 32'hAAAA, 0, 0, 0, 0, 0, ""); rd(2, 8, "R11 word ignored");
    step(1, 1, 0, 12, 32'h55, 0, 0, 0, 0, 0, ""); rd(0, 12, "R11 sof");
    // R12 unmapped and aliasing
    rd(0, 0, "R12 byte"); rd(1, 16, "R12 word"); rd(2, 4, "R12 dword");
    rd(1, 8'h22, "R12 alias"); rd(3, 0, "R12 none");
    // R13 tick and status clear together: write wins
    tick(1); step(1, 1, 1, 2, 1, 1, 2, 0, 0, 0, ""); rd(1, 2, "R13 order");
    // R3 global reset
    wrw(0, 5); rd(1, 0, "R3 cmd cleared"); rd(0, 12, "R3 sof");
    wrw(0, 2); rd(2, 8, "R3 base cleared");
    for (int i = 0; i < 3000; i++) begin
      int sel, ad, sz, v;
      sel = $urandom % 8;
      ad = (sel < 6) ? (sel * 2 + ((sel >= 4) ? (sel - 3) * 2 - 2 : 0)) : $urandom % 256;
      if (sel == 4) ad = 8; else if (sel == 5) ad = 12;
      sz = $urandom % 4;
      v = $urandom;
      if (ad == 0 && (v & 6) && ($urandom % 10) != 0) v &= ~6;
      step($urandom % 2, $urandom % 2, sz, ad, v, ($urandom % 4) == 0,
           $urandom % 4, ($urandom % 16) == 0, ($urandom % 64) == 0,
           ($urandom % 64) == 0, "");
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule